// File: doc/BRIEF.md
# Register Rename Map Stage

This block renames one instruction per cycle. An incoming instruction carries an operation code, two source architectural register numbers and one destination architectural register number. The block keeps a table with one entry per architectural register. Each entry holds the rename tag of the newest producer of that register. Both sources are looked up in this table. The resulting tags go out to an external value store, which answers with a ready flag and a value for each. The destination then takes the tag at the head of an external free pool, and that tag is written into the destination's table entry.

The result is a recoded instruction, held in an output register one cycle after acceptance. It carries the operation, the destination tag, and for each source a ready flag. When the source is ready, its data field holds the value. When it is not, the field holds the tag it is waiting for. A result broadcast that names a source tag is used in the cycle it arrives. This applies both to an instruction being renamed and to one held in the output register. The input and output sides each use a valid/ready handshake.

Top module: `rename_map_stage`

## Requirements
- R1: After reset, `out_valid` is low, `in_ready` equals `free_valid`, and the table maps architectural register i to tag i. This is visible on `rd1_tag` when `in_src1` = i.
- R2: `rd1_tag` and `rd2_tag` show the table entries for `in_src1` and `in_src2`. Both are read before the destination entry changes, so a source naming the destination register gets the older tag.
- R3: On acceptance (`in_valid` and `in_ready`), `free_take` is high for that cycle. The next cycle's `out_dst_tag` equals the `free_tag` of the acceptance cycle. Later instructions reading the destination register see that tag.
- R4: Each source in the output has a ready flag. If the flag is 1, the data field is the operand value. If it is 0, the data field is the pending tag in its low bits with zeros above.
- R5: If `bc_valid` is high and `bc_tag` equals a source's tag in the acceptance cycle, that source leaves ready, with `bc_value` as its data.
- R6: While `free_valid` is low, `in_ready` and `free_take` are low, no instruction is accepted, and the table is unchanged.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the output fields stay unchanged.
- R8: While an instruction is held in the output register, a broadcast matching a pending source's tag turns that source ready with `bc_value` as its data.
- R9: The output is registered. `out_valid` rises the cycle after acceptance and falls after a transfer that has no new acceptance.
- R10: From reset, the sequence (dst 3; src 0,1), (dst 2; src 1,0), (dst 0; src 3,1), (dst 1; src 1,3) with free tags 8, 9, 10, 11 renames to destination/source tags (8,0,1), (9,1,0), (10,8,1), (11,1,8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted this cycle when valid |
| in_op | input | OP_W | Operation code |
| in_src1 | input | log2(NUM_ARCH) | First source register |
| in_src2 | input | log2(NUM_ARCH) | Second source register |
| in_dst | input | log2(NUM_ARCH) | Destination register |
| free_valid | input | 1 | Free pool has a tag |
| free_tag | input | log2(NUM_PHYS) | Tag at the head of the free pool |
| free_take | output | 1 | Pops the free pool head |
| rd1_tag | output | log2(NUM_PHYS) | Tag looked up for source 1 |
| rd1_ready | input | 1 | Value of rd1_tag computed |
| rd1_value | input | DATA_W | Value of rd1_tag |
| rd2_tag | output | log2(NUM_PHYS) | Tag looked up for source 2 |
| rd2_ready | input | 1 | Value of rd2_tag computed |
| rd2_value | input | DATA_W | Value of rd2_tag |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | log2(NUM_PHYS) | Tag of the broadcast result |
| bc_value | input | DATA_W | Broadcast result value |
| out_valid | output | 1 | Recoded instruction present |
| out_ready | input | 1 | Downstream accepts the recoded instruction |
| out_op | output | OP_W | Operation code |
| out_dst_tag | output | log2(NUM_PHYS) | Assigned destination tag |
| out_s1_ready | output | 1 | Source 1 holds a value |
| out_s1_data | output | DATA_W | Source 1 value or pending tag |
| out_s2_ready | output | 1 | Source 2 holds a value |
| out_s2_data | output | DATA_W | Source 2 value or pending tag |

## Verification
A corrupted table entry does not show at once. It shows on `rd1_tag`/`rd2_tag` in the same cycle that a later instruction reads that register. Through the output fields it shows one cycle later, as a wrong pending tag or a wrong value. The bench compares the presented tags against its own table model before every acceptance, so a bad entry is caught at its first read. A missing write is caught on the next instruction that reads the register, and a write to the wrong register on the first read of either register. Handshake or capture faults show on the output fields in the cycle after the stall or broadcast that causes them.

// File: rtl/rename_map_stage.sv
module rename_map_stage #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  parameter int DATA_W   = 16,
  parameter int OP_W     = 4,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [AW-1:0]     in_src1,
  input  logic [AW-1:0]     in_src2,
  input  logic [AW-1:0]     in_dst,
  input  logic              free_valid,
  input  logic [PW-1:0]     free_tag,
  output logic              free_take,
  output logic [PW-1:0]     rd1_tag,
  input  logic              rd1_ready,
  input  logic [DATA_W-1:0] rd1_value,
  output logic [PW-1:0]     rd2_tag,
  input  logic              rd2_ready,
  input  logic [DATA_W-1:0] rd2_value,
  input  logic              bc_valid,
  input  logic [PW-1:0]     bc_tag,
  input  logic [DATA_W-1:0] bc_value,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OP_W-1:0]   out_op,
  output logic [PW-1:0]     out_dst_tag,
  output logic              out_s1_ready,
  output logic [DATA_W-1:0] out_s1_data,
  output logic              out_s2_ready,
  output logic [DATA_W-1:0] out_s2_data
);

  logic [PW-1:0] map_q [NUM_ARCH];

  wire fire = in_valid && in_ready;
  assign in_ready  = free_valid && (!out_valid || out_ready);
  assign free_take = fire;
  assign rd1_tag   = map_q[in_src1];
  assign rd2_tag   = map_q[in_src2];

  wire hit1 = bc_valid && (bc_tag == rd1_tag);
  wire hit2 = bc_valid && (bc_tag == rd2_tag);
  wire [DATA_W-1:0] s1_val = hit1 ? bc_value : rd1_ready ? rd1_value : DATA_W'(rd1_tag);
  wire [DATA_W-1:0] s2_val = hit2 ? bc_value : rd2_ready ? rd2_value : DATA_W'(rd2_tag);

  wire cap1 = out_valid && !out_s1_ready && bc_valid && (bc_tag == out_s1_data[PW-1:0]);
  wire cap2 = out_valid && !out_s2_ready && bc_valid && (bc_tag == out_s2_data[PW-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= PW'(i);
      out_valid    <= 1'b0;
      out_op       <= '0;
      out_dst_tag  <= '0;
      out_s1_ready <= 1'b0;
      out_s1_data  <= '0;
      out_s2_ready <= 1'b0;
      out_s2_data  <= '0;
    end else if (fire) begin
      map_q[in_dst] <= free_tag;
      out_valid     <= 1'b1;
      out_op        <= in_op;
      out_dst_tag   <= free_tag;
      out_s1_ready  <= hit1 || rd1_ready;
      out_s1_data   <= s1_val;
      out_s2_ready  <= hit2 || rd2_ready;
      out_s2_data   <= s2_val;
    end else begin
      if (out_ready) out_valid <= 1'b0;
      if (cap1) begin
        out_s1_ready <= 1'b1;
        out_s1_data  <= bc_value;
      end
      if (cap2) begin
        out_s2_ready <= 1'b1;
        out_s2_data  <= bc_value;
      end
    end
  end

endmodule

// File: rtl/rename_map_stage_chk.sv
module rename_map_stage_chk #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  parameter int DATA_W   = 16,
  parameter int OP_W     = 4,
  localparam int PW = $clog2(NUM_PHYS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              free_valid,
  input logic [PW-1:0]     free_tag,
  input logic              free_take,
  input logic [PW-1:0]     rd1_tag,
  input logic              bc_valid,
  input logic [PW-1:0]     bc_tag,
  input logic [DATA_W-1:0] bc_value,
  input logic              out_valid,
  input logic              out_ready,
  input logic [OP_W-1:0]   out_op,
  input logic [PW-1:0]     out_dst_tag,
  input logic              out_s1_ready,
  input logic [DATA_W-1:0] out_s1_data
);

  AST_NO_TAKE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !free_valid |-> (!in_ready && !free_take)); // R6

  AST_DST_FROM_POOL: assert property (@(posedge clk) disable iff (!rst_n)
    free_take |=> (out_valid && out_dst_tag == $past(free_tag))); // R3

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_dst_tag) && $stable(out_op))); // R7

  AST_NO_ACCEPT_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !free_take); // R7

  AST_SAME_CYCLE_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (free_take && bc_valid && bc_tag == rd1_tag) |=> (out_s1_ready && out_s1_data == $past(bc_value))); // R5

  AST_OUT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !free_take) |=> !out_valid); // R9

endmodule

bind rename_map_stage rename_map_stage_chk #(
  .NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .DATA_W(DATA_W), .OP_W(OP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .free_valid(free_valid), .free_tag(free_tag), .free_take(free_take),
  .rd1_tag(rd1_tag), .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
  .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
  .out_dst_tag(out_dst_tag), .out_s1_ready(out_s1_ready), .out_s1_data(out_s1_data)
);

// File: tb/test_rename_map_stage.sv
module test_rename_map_stage;
  localparam int NA = 8, NP = 16, DW = 16, OW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic in_valid = 0, in_ready, free_take, free_valid, free_en = 1;
  logic [OW-1:0] in_op = 0, out_op;
  logic [2:0] in_src1 = 0, in_src2 = 0, in_dst = 0;
  logic [3:0] free_tag, rd1_tag, rd2_tag, bc_tag = 0, out_dst_tag;
  logic rd1_ready, rd2_ready, bc_valid = 0, out_valid, out_ready = 1;
  logic [DW-1:0] rd1_value, rd2_value, bc_value = 0, out_s1_data, out_s2_data;
  logic out_s1_ready, out_s2_ready;

  logic [3:0] mdl_map [NA];
  logic st_v [NP];
  logic [DW-1:0] st_d [NP];
  logic [3:0] fq [NP];
  int fh, fcnt, n_chk = 0, n_fail = 0, k = 0;
  logic [3:0] last_t1, last_t2, last_dst;

  assign free_tag   = fq[fh];
  assign free_valid = free_en && (fcnt > 0);
  assign rd1_ready  = st_v[rd1_tag];
  assign rd1_value  = st_d[rd1_tag];
  assign rd2_ready  = st_v[rd2_tag];
  assign rd2_value  = st_d[rd2_tag];

  rename_map_stage #(.NUM_ARCH(NA), .NUM_PHYS(NP), .DATA_W(DW), .OP_W(OW)) i_rename_map_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_src1(in_src1), .in_src2(in_src2), .in_dst(in_dst),
    .free_valid(free_valid), .free_tag(free_tag), .free_take(free_take),
    .rd1_tag(rd1_tag), .rd1_ready(rd1_ready), .rd1_value(rd1_value),
    .rd2_tag(rd2_tag), .rd2_ready(rd2_ready), .rd2_value(rd2_value),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
    .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op), .out_dst_tag(out_dst_tag),
    .out_s1_ready(out_s1_ready), .out_s1_data(out_s1_data),
    .out_s2_ready(out_s2_ready), .out_s2_data(out_s2_data));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    for (int i = 0; i < NA; i++) mdl_map[i] = 4'(i);
    for (int i = 0; i < NP; i++) begin
      st_v[i] = (i < NA);
      st_d[i] = 16'(1000 + i);
    end
    for (int i = 0; i < NP; i++) fq[i] = 4'(i + NA);
    fh = 0;
    fcnt = NP - NA;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic issue(input logic [3:0] op, input logic [2:0] a, input logic [2:0] b,
                       input logic [2:0] d, input bit bc);
    logic [3:0] t1, t2, nt;
    logic r1, r2, h1, h2;
    logic [DW-1:0] v1, v2, bv;
    @(negedge clk);
    t1 = mdl_map[a];
    t2 = mdl_map[b];
    bv = 16'h5000 + 16'(k);
    in_op = op; in_src1 = a; in_src2 = b; in_dst = d; in_valid = 1;
    bc_valid = bc && !st_v[t1]; bc_tag = t1; bc_value = bv;
    #1;
    check("R2 rd1_tag", rd1_tag, t1);
    check("R2 rd2_tag", rd2_tag, t2);
    check("R3 free_take", free_take, 1);
    h1 = bc_valid && (bc_tag == t1);
    h2 = bc_valid && (bc_tag == t2);
    r1 = h1 || st_v[t1];
    r2 = h2 || st_v[t2];
    v1 = h1 ? bv : st_v[t1] ? st_d[t1] : {12'b0, t1};
    v2 = h2 ? bv : st_v[t2] ? st_d[t2] : {12'b0, t2};
    nt = fq[fh];
    @(posedge clk);
    #1;
    if (bc_valid) begin
      st_v[bc_tag] = 1;
      st_d[bc_tag] = bv;
    end
    st_v[nt] = 0;
    fq[(fh + fcnt) % NP] = mdl_map[d];
    fh = (fh + 1) % NP;
    mdl_map[d] = nt;
    in_valid = 0;
    bc_valid = 0;
    @(negedge clk);
    check("R9 out_valid", out_valid, 1);
    check("R3 out_op", out_op, op);
    check("R3 out_dst_tag", out_dst_tag, nt);
    check("R4 s1 ready", out_s1_ready, r1);
    check("R4 s1 data", out_s1_data, v1);
    check("R4 s2 ready", out_s2_ready, r2);
    check("R4 s2 data", out_s2_data, v2);
    if (h1) check("R5 forward", out_s1_data, bv);
    last_t1 = t1; last_t2 = t2; last_dst = nt;
    k++;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [3:0] held_tag, pend, saved;
    do_reset();
    check("R1 out_valid", out_valid, 0);
    check("R1 in_ready", in_ready, 1);
    for (int i = 0; i < NA; i++) begin
      @(negedge clk);
      in_src1 = 3'(i);
      #1 check("R1 identity", rd1_tag, i);
    end

    issue(4'h1, 3'd0, 3'd1, 3'd3, 0);
    check("R10 i1", {last_dst, last_t1, last_t2}, {4'd8, 4'd0, 4'd1});
    issue(4'h2, 3'd1, 3'd0, 3'd2, 0);
    check("R10 i2", {last_dst, last_t1, last_t2}, {4'd9, 4'd1, 4'd0});
    issue(4'h3, 3'd3, 3'd1, 3'd0, 0);
    check("R10 i3", {last_dst, last_t1, last_t2}, {4'd10, 4'd8, 4'd1});
    check("R10 i3 pending", out_s1_data, 8);
    issue(4'h4, 3'd1, 3'd3, 3'd1, 0);
    check("R10 i4", {last_dst, last_t1, last_t2}, {4'd11, 4'd1, 4'd8});
    check("R10 i4 pending", {out_s2_ready, out_s2_data[3:0]}, {1'b0, 4'd8});

    for (int d = 0; d < NA; d++)
      for (int s = 0; s < NA; s++)
        issue(4'(d + s), 3'(s), 3'(d), 3'(d), (k % 3) == 0);

    @(negedge clk);
    saved = mdl_map[4];
    free_en = 0;
    in_valid = 1; in_src1 = 3'd0; in_src2 = 3'd0; in_dst = 3'd4;
    #1;
    check("R6 in_ready", in_ready, 0);
    check("R6 free_take", free_take, 0);
    @(posedge clk);
    #1 in_valid = 0;
    @(negedge clk);
    check("R9 drained", out_valid, 0);
    free_en = 1;
    issue(4'h7, 3'd4, 3'd5, 3'd6, 0);
    check("R6 map kept", last_t1, saved);

    issue(4'h8, 3'd0, 3'd0, 3'd5, 0);
    @(negedge clk);
    out_ready = 0;
    issue(4'h9, 3'd5, 3'd0, 3'd6, 0);
    held_tag = last_dst;
    pend = last_t1;
    check("R4 pending held", out_s1_ready, 0);
    #1 check("R7 in_ready", in_ready, 0);
    in_valid = 1; in_src1 = 3'd1; in_dst = 3'd2;
    @(posedge clk);
    #1 in_valid = 0;
    @(negedge clk);
    check("R7 dst held", out_dst_tag, held_tag);
    check("R7 op held", out_op, 4'h9);
    check("R7 still valid", out_valid, 1);
    bc_valid = 1; bc_tag = pend; bc_value = 16'hBEEF;
    @(posedge clk);
    #1;
    bc_valid = 0;
    st_v[pend] = 1;
    st_d[pend] = 16'hBEEF;
    @(negedge clk);
    check("R8 captured ready", out_s1_ready, 1);
    check("R8 captured data", out_s1_data, 16'hBEEF);
    out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    check("R9 out_valid falls", out_valid, 0);
    issue(4'hA, 3'd2, 3'd6, 3'd7, 0);
    check("R7 map kept", last_t1, mdl_map[2]);
    finish_run();
  end
endmodule